// File: doc/BRIEF.md
# Table-Driven Fixed-Coefficient Multiplier

This block multiplies an unsigned 8-bit sample by a coefficient that is fixed when the design is built. It uses no general-purpose multiplier. The sample is cut into an upper and a lower 4-bit nibble. Each nibble selects one entry from its own 16-entry table. Every table entry holds a multiple of the coefficient, and the tables are computed at elaboration. The upper partial result is moved four bit positions to the left. A single adder then sums it with the lower partial result to give the full 16-bit product.

The block takes one sample per clock, qualified by a valid strobe, and returns one product per clock, qualified by its own valid strobe. A register stage sits on each side of the lookup-and-add logic, so each result appears a fixed two cycles after its sample. A filter datapath uses one copy of the block for each constant tap.

Top module: `nib_table_mult`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted sample has passed through, `out_valid` is 0 and `out_product` is 0.
- R2: The upper nibble is `in_sample[7:4]` and carries a weight of 16. The lower nibble is `in_sample[3:0]` and carries a weight of 1. The product equals (upper × COEF) × 16 + (lower × COEF).
- R3: For every one of the 256 sample values, `out_product` equals `in_sample × COEF`, held as a 16-bit unsigned value.
- R4: The design is correct at both ends of the coefficient range. With COEF = 0 every product is 0. With COEF = 255 and sample 255 the product is 65025.
- R5: If a sample is taken at rising edge N, its `out_valid` and `out_product` appear after rising edge N+1. The latency is exactly two cycles.
- R6: Samples presented on consecutive cycles are all accepted. Their products come out on consecutive cycles, in the same order.
- R7: While `out_valid` is 0, `out_product` keeps the last product it delivered.
- R8: When `in_valid` is 0, `in_sample` is ignored. No valid result is produced for it, and it does not change `out_product`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_sample` as a sample to process |
| in_sample | input | 8 | Unsigned sample value |
| out_valid | output | 1 | Marks `out_product` as a fresh result |
| out_product | output | 16 | Unsigned product of sample and coefficient |

## Verification
A sample is driven on a falling edge and captured at the next rising edge. Its product is therefore present after the rising edge that follows. The bench reads it on the second falling edge after it drove the sample, and never at a clock edge. In the streaming sweep, the check made at each falling edge covers the sample driven two falling edges earlier. The single-pulse test steps through the cycles one at a time: before the product is due it confirms that `out_valid` is still low, and at the due cycle it expects the product. The idle tests keep `in_valid` low and wiggle `in_sample`. They then confirm over several cycles that `out_valid` stays low and that `out_product` does not move.

// File: rtl/nibmul_pkg.sv
package nibmul_pkg;
    // Default sizing shared by the multiplier and its benches.
    localparam int NM_DIN_W     = 8;
    localparam int NM_COEF_W    = 8;
    localparam int NM_COEF_DEF  = 173;
endpackage

// File: rtl/nib_lut.sv
// One table of multiples of a constant, indexed by a nibble.
module nib_lut #(
    parameter int                 NIB_W  = 4,
    parameter int                 COEF_W = 8,
    parameter logic [COEF_W-1:0]  COEF   = '0,
    localparam int                OUT_W  = NIB_W + COEF_W,
    localparam int                DEPTH  = 1 << NIB_W
) (
    input  logic [NIB_W-1:0] addr,
    output logic [OUT_W-1:0] data
);
    logic [OUT_W-1:0] table_q [DEPTH];

    // Entry j holds j multiples of the coefficient.
    for (genvar j = 0; j < DEPTH; j++) begin : g_entry
        assign table_q[j] = OUT_W'(j) * OUT_W'(COEF);
    end

    assign data = table_q[addr];
endmodule

// File: rtl/nib_align_add.sv
// Shifts the upper partial product by one nibble and adds the lower one.
module nib_align_add #(
    parameter int  NIB_W  = 4,
    parameter int  PART_W = 12,
    localparam int SUM_W  = PART_W + NIB_W
) (
    input  logic [PART_W-1:0] lo_part,
    input  logic [PART_W-1:0] hi_part,
    output logic [SUM_W-1:0]  sum
);
    logic [SUM_W-1:0] hi_aligned;
    logic [SUM_W-1:0] lo_ext;

    always_comb begin
        hi_aligned = {hi_part, {NIB_W{1'b0}}};
        lo_ext     = {{NIB_W{1'b0}}, lo_part};
        sum        = hi_aligned + lo_ext;
    end
endmodule

// File: rtl/nib_table_mult.sv
module nib_table_mult
    import nibmul_pkg::*;
#(
    parameter int                 DIN_W  = NM_DIN_W,
    parameter int                 COEF_W = NM_COEF_W,
    parameter logic [COEF_W-1:0]  COEF   = COEF_W'(NM_COEF_DEF),
    localparam int                PROD_W = DIN_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DIN_W-1:0]  in_sample,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_product
);
    localparam int NIB_CNT = 2;
    localparam int NIB_W   = DIN_W / NIB_CNT;
    localparam int PART_W  = NIB_W + COEF_W;

    typedef struct packed {
        logic              in_vld;
        logic [DIN_W-1:0]  in_smp;
        logic              out_vld;
        logic [PROD_W-1:0] out_prod;
    } state_t;

    state_t state_d, state_q;

    logic [PART_W-1:0] part [NIB_CNT];
    logic [PROD_W-1:0] prod_sum;

    // Index 0 is the lower nibble, index 1 the upper nibble.
    for (genvar n = 0; n < NIB_CNT; n++) begin : g_nib
        nib_lut #(
            .NIB_W  (NIB_W),
            .COEF_W (COEF_W),
            .COEF   (COEF)
        ) u_lut (
            .addr (state_q.in_smp[n*NIB_W +: NIB_W]),
            .data (part[n])
        );
    end

    nib_align_add #(
        .NIB_W  (NIB_W),
        .PART_W (PART_W)
    ) u_add (
        .lo_part (part[0]),
        .hi_part (part[1]),
        .sum     (prod_sum)
    );

    always_comb begin
        state_d         = state_q;
        state_d.in_vld  = in_valid;
        if (in_valid) begin
            state_d.in_smp = in_sample;
        end
        state_d.out_vld = state_q.in_vld;
        if (state_q.in_vld) begin
            state_d.out_prod = prod_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.out_vld;
    assign out_product = state_q.out_prod;

    // Counts edges since reset so that history-based checks stay in range.
    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (seen_q != 2'd2) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd1) |-> (!out_valid && out_product == '0));

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2 && out_valid) |->
            (out_product == PROD_W'($past(in_sample, 2)) * PROD_W'(COEF)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0 && !out_valid) |-> $stable(out_product));
endmodule

// File: tb/nib_table_mult_tb.sv
module nib_table_mult_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NDUT = 4;
    localparam logic [7:0] KS [NDUT] = '{8'd173, 8'd0, 8'd255, 8'd1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  smp = 8'd0;
    logic        ov [NDUT];
    logic [15:0] op [NDUT];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_table_mult dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_sample(smp),
        .out_valid(ov[0]), .out_product(op[0]));
    nib_table_mult #(.COEF(8'd0)) dut_k0 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_sample(smp),
        .out_valid(ov[1]), .out_product(op[1]));
    nib_table_mult #(.COEF(8'd255)) dut_k255 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_sample(smp),
        .out_valid(ov[2]), .out_product(op[2]));
    nib_table_mult #(.COEF(8'd1)) dut_k1 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_sample(smp),
        .out_valid(ov[3]), .out_product(op[3]));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int s, input int k);
        return (s * k) & 16'hFFFF;
    endfunction

    // R1: quiet outputs during and just after reset
    task automatic t_reset();
        repeat (3) @(negedge clk);
        for (int d = 0; d < NDUT; d++) begin
            chk("R1 valid in reset", int'(ov[d]), 0);
            chk("R1 product in reset", int'(op[d]), 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int d = 0; d < NDUT; d++) begin
            chk("R1 valid after reset", int'(ov[d]), 0);
            chk("R1 product after reset", int'(op[d]), 0);
        end
    endtask

    // R5: one pulse, cycle-exact arrival
    task automatic t_latency();
        @(negedge clk);
        vld = 1'b1; smp = 8'hC7;
        @(negedge clk);
        vld = 1'b0; smp = 8'h00;
        chk("R5 not due after one edge", int'(ov[0]), 0);
        @(negedge clk);
        chk("R5 valid after two edges", int'(ov[0]), 1);
        chk("R5 product at due cycle", int'(op[0]), model(8'hC7, KS[0]));
        @(negedge clk);
        chk("R5 single valid pulse", int'(ov[0]), 0);
    endtask

    // R2: nibble weighting, upper-only and lower-only samples
    task automatic t_nibbles();
        @(negedge clk);
        vld = 1'b1; smp = 8'hF0;
        @(negedge clk);
        smp = 8'h0F;
        @(negedge clk);
        vld = 1'b0;
        chk("R2 upper nibble weight 16", int'(op[0]), 15 * 173 * 16);
        @(negedge clk);
        chk("R2 lower nibble weight 1", int'(op[0]), 15 * 173);
    endtask

    // R3, R4, R6: back-to-back sweep of all 256 samples on every coefficient
    task automatic t_sweep();
        int bad_order = 0;
        for (int i = 0; i < 258; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                for (int d = 0; d < NDUT; d++) begin
                    if (!ov[d]) bad_order++;
                    chk((d == 1 || d == 2) ? "R4 edge coefficient" : "R3 sweep",
                        int'(op[d]), model(i - 2, KS[d]));
                end
            end
            if (i < 256) begin
                vld = 1'b1; smp = 8'(i);
            end else begin
                vld = 1'b0; smp = 8'h5A;
            end
        end
        chk("R6 valid every streamed cycle", bad_order, 0);
        chk("R4 max product", 255 * 255, model(255, KS[2]));
    endtask

    // R7, R8: invalid samples leave the result untouched
    task automatic t_idle();
        int last;
        @(negedge clk);
        last = int'(op[0]);
        chk("R7 held product is last result", last, model(255, KS[0]));
        for (int c = 0; c < 6; c++) begin
            vld = 1'b0; smp = 8'(8'h11 * c + 8'h3);
            @(negedge clk);
            chk("R8 no valid for gated sample", int'(ov[0]), 0);
            chk("R7 product held while idle", int'(op[0]), last);
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_nibbles();
        t_sweep();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule